// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is a watchdog timer driven by a timebase tick and controlled through one 8-bit control/status register. Software starts the watchdog by writing a zero into the enable/clear bit. Every later zero written there while the watchdog runs restarts the count. If software stops writing it, the counter reaches the terminal count of the selected interval. The block then raises a one-clock reset request and stops itself.

The same register also records what caused recent resets. A power-on reset, an external reset pin event, a software reset request and a watchdog expiry each set their own flag and leave the other flags alone. Any read of the register returns the flags and clears them. Hardware standby stops the watchdog without touching the flags. The system reset generator, the clock prescaler and the bus fabric sit outside the block.

Top module: `wdog_rstsrc`

## Requirements
- R1: After power-on reset (`rst_n` low) the register reads 8'h84. The power-on flag is 1, the other flags are 0, the interval code is 00, and the watchdog is stopped, so ticks cause no reset request until it is started.
- R2: Register layout on read: bit 7 is the power-on flag, bit 6 reads 0, bit 5 is the watchdog flag, bit 4 is the external flag, bit 3 is the software flag, bit 2 always reads 1, and bits 1:0 are the interval code.
- R3: A pulse on `ext_rst_i` sets bit 4 and a pulse on `sw_rst_i` sets bit 3 at the next edge. The other flags keep their values.
- R4: A read (`reg_rd_i` high) returns the flags as they were before the edge. At that edge bits 7, 5, 4 and 3 clear to 0, except as R5 states. The flags are not writable.
- R5: If a reset-cause event occurs in the same cycle as a read, that event's flag is 1 after the edge.
- R6: A write with bit 2 = 0 while the watchdog is stopped starts it with the count at 0. A write with bit 2 = 1 neither starts the watchdog nor clears the count.
- R7: While the watchdog runs, a write with bit 2 = 0 returns the count to 0. A clear in the same cycle as a tick wins over the tick.
- R8: With interval code k (0..3), `wdog_rst_o` pulses for exactly one clock at the edge of the 2^(3+2k)-th tick after the last start or clear, provided no clear is written in that time. The watchdog flag (bit 5) sets at the same edge and the watchdog stops.
- R9: A `stby_i` pulse stops the watchdog and zeroes the count, and it takes priority over a write in the same cycle. It leaves all flags unchanged.
- R10: Bits 1:0 can be written at any time and read back. The terminal count used for a tick follows the code held before that edge.
- R11: The count advances only on cycles where `tick_i` is high while the watchdog runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Timebase tick strobe |
| ext_rst_i | input | 1 | External reset pin event, one-cycle pulse |
| sw_rst_i | input | 1 | Software reset request event, one-cycle pulse |
| stby_i | input | 1 | Hardware standby entry, one-cycle pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (clears the flags) |
| reg_rdata_o | output | 8 | Register read data |
| wdog_rst_o | output | 1 | Watchdog reset request, one-clock pulse |
| flags_o | output | 4 | Flags {power-on, watchdog, external, software} |

## Verification
The assertions check on every cycle the fixed read bits, that each flag is set by its own event, that flags are kept when there is neither an event nor a read, that a read clears them, and that the reset request is a single cycle that coincides with the watchdog flag. The bench's scenarios are needed for behaviour that depends on a count. That covers the exact tick on which each of the four intervals expires, the difference between the first zero write (start) and later zero writes (clear), and the absence of any expiry while clears keep arriving or after standby.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int REG_W   = 8;
   localparam int BIT_POR = 7;
   localparam int BIT_WDT = 5;
   localparam int BIT_EXT = 4;
   localparam int BIT_SW  = 3;
   localparam int BIT_EN  = 2;
   localparam int SEL_W   = 2;
   localparam int N_SEL   = 1 << SEL_W;

   typedef struct packed {
      logic por;
      logic wdt;
      logic ext;
      logic sw;
   } rst_flags_t;

   function automatic int sel_exp(input int base, input int step, input int code);
      return base + step * code;
   endfunction

endpackage

// File: rtl/wdog_tick_cond.sv
module wdog_tick_cond #(
   parameter bit PULSE_TICK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic tick_o
);

   generate
      if (PULSE_TICK) begin : g_pulse
         assign tick_o = tick_i;
      end else begin : g_edge
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= tick_i;
         end
         assign tick_o = tick_i & ~tick_q;
      end
   endgenerate

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int BASE_EXP = 3,
   parameter int STEP_EXP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_clr_i,
   input  logic             stby_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             expire_o,
   output logic             wdog_rst_o
);

   localparam int CNT_W = BASE_EXP + (N_SEL - 1) * STEP_EXP;

   logic [CNT_W-1:0] lim_tab [N_SEL];
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [CNT_W-1:0] lim_m1;

   genvar k;
   generate
      for (k = 0; k < N_SEL; k++) begin : g_lim
         localparam int EXP_K = sel_exp(BASE_EXP, STEP_EXP, k);
         assign lim_tab[k] = CNT_W'((64'd1 << EXP_K) - 64'd1);
      end
   endgenerate

   assign lim_m1   = lim_tab[sel_i];
   assign expire_o = run_q & tick_i & ~start_clr_i & ~stby_i & (cnt_q == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         cnt_q      <= '0;
         wdog_rst_o <= 1'b0;
      end else begin
         wdog_rst_o <= expire_o;
         if (stby_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (start_clr_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
         end else if (expire_o) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (run_q && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   input  logic             reg_rd_i,
   input  logic             ext_rst_i,
   input  logic             sw_rst_i,
   input  logic             expire_i,
   output logic [REG_W-1:0] reg_rdata_o,
   output logic             start_clr_o,
   output logic [SEL_W-1:0] sel_o,
   output rst_flags_t       flags_o
);

   rst_flags_t flags_q, flags_d;
   logic [SEL_W-1:0] sel_q;

   assign start_clr_o = reg_wr_i & ~reg_wdata_i[BIT_EN];

   always_comb begin
      flags_d = reg_rd_i ? '0 : flags_q;
      if (ext_rst_i) flags_d.ext = 1'b1;
      if (sw_rst_i)  flags_d.sw  = 1'b1;
      if (expire_i)  flags_d.wdt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '{por: 1'b1, wdt: 1'b0, ext: 1'b0, sw: 1'b0};
         sel_q   <= '0;
      end else begin
         flags_q <= flags_d;
         if (reg_wr_i) sel_q <= reg_wdata_i[SEL_W-1:0];
      end
   end

   always_comb begin
      reg_rdata_o                 = '0;
      reg_rdata_o[BIT_POR]        = flags_q.por;
      reg_rdata_o[BIT_WDT]        = flags_q.wdt;
      reg_rdata_o[BIT_EXT]        = flags_q.ext;
      reg_rdata_o[BIT_SW]         = flags_q.sw;
      reg_rdata_o[BIT_EN]         = 1'b1;
      reg_rdata_o[SEL_W-1:0]      = sel_q;
   end

   assign sel_o   = sel_q;
   assign flags_o = flags_q;

endmodule

// File: rtl/wdog_rstsrc.sv
module wdog_rstsrc #(
   parameter int BASE_EXP   = 3,
   parameter int STEP_EXP   = 2,
   parameter bit PULSE_TICK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       ext_rst_i,
   input  logic       sw_rst_i,
   input  logic       stby_i,
   input  logic       reg_wr_i,
   input  logic [7:0] reg_wdata_i,
   input  logic       reg_rd_i,
   output logic [7:0] reg_rdata_o,
   output logic       wdog_rst_o,
   output logic [3:0] flags_o
);
   import wdog_pkg::*;

   localparam int MAX_EXP = BASE_EXP + (N_SEL - 1) * STEP_EXP;

   generate
      if (BASE_EXP < 1 || STEP_EXP < 0 || MAX_EXP > 30) begin : g_bad_cfg
         $error("wdog_rstsrc: interval exponents out of range");
      end
   endgenerate

   logic             tick_c;
   logic             start_clr;
   logic             expire;
   logic [SEL_W-1:0] sel;
   rst_flags_t       flags;

   wdog_tick_cond #(.PULSE_TICK(PULSE_TICK)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .tick_o (tick_c)
   );

   wdog_regif u_regif (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_i    (reg_wr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rd_i    (reg_rd_i),
      .ext_rst_i   (ext_rst_i),
      .sw_rst_i    (sw_rst_i),
      .expire_i    (expire),
      .reg_rdata_o (reg_rdata_o),
      .start_clr_o (start_clr),
      .sel_o       (sel),
      .flags_o     (flags)
   );

   wdog_counter #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_c),
      .start_clr_i (start_clr),
      .stby_i      (stby_i),
      .sel_i       (sel),
      .expire_o    (expire),
      .wdog_rst_o  (wdog_rst_o)
   );

   assign flags_o = flags;

endmodule

// File: rtl/wdog_rstsrc_chk.sv
module wdog_rstsrc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ext_rst_i,
   input logic       sw_rst_i,
   input logic       stby_i,
   input logic       reg_rd_i,
   input logic [7:0] reg_rdata_o,
   input logic       wdog_rst_o,
   input logic [3:0] flags_o
);

   // R2
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[2] && !reg_rdata_o[6]);

   // R3
   ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst_i |=> flags_o[1]);

   // R3
   sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_i |=> flags_o[0]);

   // R3
   ext_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rd_i && !ext_rst_i) |=> (flags_o[1] == $past(flags_o[1])));

   // R4
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && !ext_rst_i && !sw_rst_i) |=> (flags_o[3] == 1'b0 && flags_o[1:0] == 2'b00));

   // R8
   pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_o |=> !wdog_rst_o);

   // R8
   pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_o |-> flags_o[2]);

   // R9
   stby_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stby_i |=> !wdog_rst_o);

endmodule

bind wdog_rstsrc wdog_rstsrc_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ext_rst_i   (ext_rst_i),
   .sw_rst_i    (sw_rst_i),
   .stby_i      (stby_i),
   .reg_rd_i    (reg_rd_i),
   .reg_rdata_o (reg_rdata_o),
   .wdog_rst_o  (wdog_rst_o),
   .flags_o     (flags_o)
);

// File: tb/wdog_rstsrc_tb.sv
`timescale 1ns/1ps
module wdog_rstsrc_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       ext_rst_i = 1'b0;
   logic       sw_rst_i = 1'b0;
   logic       stby_i = 1'b0;
   logic       reg_wr_i = 1'b0;
   logic [7:0] reg_wdata_i = 8'h00;
   logic       reg_rd_i = 1'b0;
   logic [7:0] reg_rdata_o;
   logic       wdog_rst_o;
   logic [3:0] flags_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // model state
   bit       m_por, m_wdt, m_ext, m_sw, m_run, m_rst;
   bit [1:0] m_sel;
   int       m_cnt;

   always #4 clk = ~clk;

   wdog_rstsrc u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_rst_i(ext_rst_i),
      .sw_rst_i(sw_rst_i), .stby_i(stby_i), .reg_wr_i(reg_wr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o),
      .wdog_rst_o(wdog_rst_o), .flags_o(flags_o)
   );

   function automatic int lim_of(input bit [1:0] sel);
      return 1 << (3 + 2 * sel);
   endfunction

   function automatic logic [7:0] exp_rd();
      return {m_por, 1'b0, m_wdt, m_ext, m_sw, 1'b1, m_sel};
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string what);
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, expv);
      end
   endtask

   task automatic step(input bit wr, input bit [7:0] wd, input bit rd,
                       input bit ext, input bit sw, input bit sb, input bit tk);
      bit clr, exp_e;
      @(negedge clk);
      reg_wr_i = wr; reg_wdata_i = wd; reg_rd_i = rd;
      ext_rst_i = ext; sw_rst_i = sw; stby_i = sb; tick_i = tk;
      #1;
      chk(reg_rdata_o, exp_rd(), "rdata");
      clr   = wr && !wd[2];
      exp_e = m_run && tk && !clr && !sb && (m_cnt == lim_of(m_sel) - 1);
      if (sb) begin m_run = 0; m_cnt = 0; end
      else if (clr) begin m_run = 1; m_cnt = 0; end
      else if (exp_e) begin m_run = 0; m_cnt = 0; end
      else if (m_run && tk) m_cnt++;
      if (rd) begin m_por = 0; m_wdt = 0; m_ext = 0; m_sw = 0; end
      if (ext) m_ext = 1;
      if (sw) m_sw = 1;
      if (exp_e) m_wdt = 1;
      if (wr) m_sel = wd[1:0];
      m_rst = exp_e;
      @(posedge clk);
      #1;
      chk({7'd0, wdog_rst_o}, {7'd0, m_rst}, "wdog_rst_o");
      chk({4'd0, flags_o}, {4'd0, m_por, m_wdt, m_ext, m_sw}, "flags_o");
   endtask

   task automatic idle(input int n, input bit tk);
      for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0, tk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5EED_0042);
      m_por = 1; m_wdt = 0; m_ext = 0; m_sw = 0; m_run = 0; m_rst = 0;
      m_sel = 0; m_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset value of the register
      cur_req = "R1";
      chk(reg_rdata_o, 8'h84, "reset value");
      idle(40, 1);
      // R6: write with enable bit = 1 does not start
      cur_req = "R6";
      step(1, 8'h04, 0, 0, 0, 0, 0);
      idle(20, 1);
      // R8: start at interval 0, expire on the 8th tick
      cur_req = "R8";
      step(1, 8'h00, 0, 0, 0, 0, 0);
      idle(7, 1);
      chk({7'd0, wdog_rst_o}, 8'h00, "no early expiry");
      idle(1, 1);
      chk({7'd0, wdog_rst_o}, 8'h01, "expiry on 8th tick");
      idle(20, 1);
      // R4 / R2: read returns then clears flags
      cur_req = "R4";
      step(0, 8'h00, 1, 0, 0, 0, 0);
      idle(1, 0);
      chk(reg_rdata_o, 8'h04, "cleared after read");
      // R3: mixed resets retain other flags
      cur_req = "R3";
      step(0, 8'h00, 0, 1, 0, 0, 0);
      idle(2, 0);
      step(0, 8'h00, 0, 0, 1, 0, 0);
      idle(1, 0);
      chk(reg_rdata_o, 8'h1C, "ext and sw both held");
      // R5: event in a read cycle wins
      cur_req = "R5";
      step(0, 8'h00, 1, 1, 0, 0, 0);
      idle(1, 0);
      chk(reg_rdata_o, 8'h14, "ext kept over read clear");
      // R7: repeated clears prevent expiry; clear beats tick
      cur_req = "R7";
      step(1, 8'h01, 0, 0, 0, 0, 0);
      for (int j = 0; j < 10; j++) begin
         idle(30, 1);
         step(1, 8'h01, 0, 0, 0, 0, 1);
      end
      // R6: enable=1 write while running does not clear
      cur_req = "R6";
      idle(20, 1);
      step(1, 8'h05, 0, 0, 0, 0, 1);
      idle(11, 1);
      // R11: no ticks, no advance
      cur_req = "R11";
      step(1, 8'h01, 0, 0, 0, 0, 0);
      idle(200, 0);
      idle(40, 1);
      // R9: standby stops and preserves flags
      cur_req = "R9";
      step(1, 8'h00, 0, 0, 0, 0, 0);
      idle(5, 1);
      step(1, 8'h00, 0, 0, 0, 1, 1);
      idle(30, 1);
      // R8 / R10: every interval code
      for (int k = 0; k < 4; k++) begin
         cur_req = "R10";
         step(0, 8'h00, 0, 0, 0, 1, 0);
         step(1, 8'h04 | k[7:0], 0, 0, 0, 0, 0);
         cur_req = "R8";
         step(1, k[7:0], 0, 0, 0, 0, 0);
         idle(lim_of(k[1:0]) + 3, 1);
      end
      // random mix covering all requirements
      cur_req = "R3,R4,R5,R7,R8,R9,R10";
      for (int i = 0; i < 4000; i++) begin
         bit [7:0] wd;
         wd = 8'($urandom);
         step(($urandom % 40) == 0, wd, ($urandom % 10) == 0,
              ($urandom % 30) == 0, ($urandom % 30) == 0,
              ($urandom % 200) == 0, ($urandom % 2) == 0);
      end
      idle(2, 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule